// File: doc/BRIEF.md
# Cascadable One-of-Eight Decoder with Mixed-Polarity Enable

This block turns a three-bit binary select into a one-of-eight active-low output pattern. The decoder is gated by three enable inputs: two active-low and one active-high. When all three enables are in their active state, exactly one output line is driven low: the line whose index equals the select value. When any enable is inactive, every output is held high, whatever the select is. The enable term feeds every output gate, so no output can go active while the decoder is disabled.

The same top module also contains a sixteen-output decoder built from two of the eight-output units. The top bit of a four-bit select drives the enables of the two units with opposite polarity. The lower unit covers indices 0 to 7 and the upper unit covers indices 8 to 15. A separate active-low global enable disables both units at once. Both decoders are purely combinational. Typical uses are address decoding for peripheral selection, and producing sequencing strobes from a free-running counter.

Top module: `bdec_top`

## Requirements
- R1: The eight-output decoder is enabled only when `oct_en_a_n` is 0, `oct_en_b_n` is 0 and `oct_en_c` is 1. Any other enable combination counts as disabled.
- R2: When enabled, `oct_y_n[k]` is 0 for k equal to `oct_sel` (bit 2 is the MSB, bit 0 the LSB), and every other bit of `oct_y_n` is 1.
- R3: When disabled, `oct_y_n` is 8'hFF for every value of `oct_sel`.
- R4: At most one bit of `oct_y_n` is 0 at any time.
- R5: With `hex_en_n` = 0 and `hex_sel[3]` = 0, `hex_y_n[hex_sel[2:0]]` is 0 and all other bits are 1. In particular `hex_y_n[15:8]` is 8'hFF.
- R6: With `hex_en_n` = 0 and `hex_sel[3]` = 1, `hex_y_n[8 + hex_sel[2:0]]` is 0 and all other bits are 1. In particular `hex_y_n[7:0]` is 8'hFF.
- R7: With `hex_en_n` = 1, `hex_y_n` is 16'hFFFF for every value of `hex_sel`. At most one bit of `hex_y_n` is 0 at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| oct_sel | input | 3 | Binary select of the eight-output decoder |
| oct_en_a_n | input | 1 | First enable, active low |
| oct_en_b_n | input | 1 | Second enable, active low |
| oct_en_c | input | 1 | Third enable, active high |
| oct_y_n | output | 8 | One-of-eight outputs, active low |
| hex_sel | input | 4 | Binary select of the sixteen-output decoder; bit 3 steers the two halves |
| hex_en_n | input | 1 | Global enable of the sixteen-output decoder, active low |
| hex_y_n | output | 16 | One-of-sixteen outputs, active low |

## Verification
The assertions are evaluated every time the inputs change. They check that no output goes active while the decoder is disabled, that at most one line is low, that the selected line is the low one, and that the inactive half of the sixteen-output decoder stays fully high. They cannot show that every one of the 64 select-and-enable combinations of the eight-output unit, and every select of the cascade, has actually been applied. The bench covers this by sweeping all combinations exhaustively and then adding seeded random vectors.

// File: rtl/bdec_pkg.sv
package bdec_pkg;
    localparam int SEL_W  = 3;
    localparam int OUT_N  = 1 << SEL_W;
    localparam int HEX_W  = SEL_W + 1;
    localparam int HEX_N  = 2 * OUT_N;
    localparam int NLO    = 2;
    localparam int NHI    = 1;
endpackage

// File: rtl/bdec_en_gate.sv
module bdec_en_gate #(
    parameter int NLO = bdec_pkg::NLO,
    parameter int NHI = bdec_pkg::NHI
) (
    input  logic [NLO-1:0] act_lo_n,
    input  logic [NHI-1:0] act_hi,
    output logic           en
);
    // Enable term: every low-active input low and every high-active input high
    always_comb begin
        en = (~|act_lo_n) & (&act_hi);
    end
endmodule

// File: rtl/bdec_core.sv
module bdec_core #(
    parameter int SEL_W = bdec_pkg::SEL_W,
    localparam int N    = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             en,
    output logic [N-1:0]     y_n
);
    // One NAND per output line; the enable term is an input of each gate
    for (genvar i = 0; i < N; i++) begin : g_line
        assign y_n[i] = ~(en & (sel == SEL_W'(i)));
    end
endmodule

// File: rtl/bdec_oct.sv
module bdec_oct #(
    parameter int SEL_W = bdec_pkg::SEL_W,
    localparam int N    = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             en_a_n,
    input  logic             en_b_n,
    input  logic             en_c,
    output logic [N-1:0]     y_n
);
    logic en;

    bdec_en_gate #(.NLO(2), .NHI(1)) u_gate (
        .act_lo_n ({en_b_n, en_a_n}),
        .act_hi   (en_c),
        .en       (en)
    );

    bdec_core #(.SEL_W(SEL_W)) u_core (
        .sel (sel),
        .en  (en),
        .y_n (y_n)
    );
endmodule

// File: rtl/bdec_cascade.sv
module bdec_cascade #(
    parameter int SUB_W = bdec_pkg::SEL_W,
    localparam int SUB_N = 1 << SUB_W
) (
    input  logic [SUB_W:0]     sel,
    input  logic               en_n,
    output logic [2*SUB_N-1:0] y_n
);
    // Top select bit lands on a low-active enable of the lower unit and on
    // the high-active enable of the upper unit, so one half runs at a time.
    for (genvar k = 0; k < 2; k++) begin : g_half
        logic lo2_n;
        logic hi;
        if (k == 0) begin : g_lower
            assign lo2_n = sel[SUB_W];
            assign hi    = 1'b1;
        end else begin : g_upper
            assign lo2_n = 1'b0;
            assign hi    = sel[SUB_W];
        end

        bdec_oct #(.SEL_W(SUB_W)) u_unit (
            .sel    (sel[SUB_W-1:0]),
            .en_a_n (en_n),
            .en_b_n (lo2_n),
            .en_c   (hi),
            .y_n    (y_n[k*SUB_N +: SUB_N])
        );
    end
endmodule

// File: rtl/bdec_top.sv
module bdec_top #(
    parameter int SEL_W = bdec_pkg::SEL_W,
    localparam int N    = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] oct_sel,
    input  logic             oct_en_a_n,
    input  logic             oct_en_b_n,
    input  logic             oct_en_c,
    output logic [N-1:0]     oct_y_n,
    input  logic [SEL_W:0]   hex_sel,
    input  logic             hex_en_n,
    output logic [2*N-1:0]   hex_y_n
);
    bdec_oct #(.SEL_W(SEL_W)) u_oct (
        .sel    (oct_sel),
        .en_a_n (oct_en_a_n),
        .en_b_n (oct_en_b_n),
        .en_c   (oct_en_c),
        .y_n    (oct_y_n)
    );

    bdec_cascade #(.SUB_W(SEL_W)) u_hex (
        .sel  (hex_sel),
        .en_n (hex_en_n),
        .y_n  (hex_y_n)
    );
endmodule

// File: rtl/bdec_chk.sv
module bdec_chk #(
    parameter int SEL_W = bdec_pkg::SEL_W,
    localparam int N    = 1 << SEL_W
) (
    input logic [SEL_W-1:0] oct_sel,
    input logic             oct_en_a_n,
    input logic             oct_en_b_n,
    input logic             oct_en_c,
    input logic [N-1:0]     oct_y_n,
    input logic [SEL_W:0]   hex_sel,
    input logic             hex_en_n,
    input logic [2*N-1:0]   hex_y_n
);
    logic oct_known;
    logic hex_known;
    logic oct_on;

    always_comb begin
        oct_known = !$isunknown({oct_sel, oct_en_a_n, oct_en_b_n, oct_en_c, oct_y_n});
        hex_known = !$isunknown({hex_sel, hex_en_n, hex_y_n});
        oct_on    = !oct_en_a_n && !oct_en_b_n && oct_en_c;
        if (oct_known) begin
            AST_ACTIVE_NEEDS_EN: assert ((&oct_y_n) || oct_on);               // R1
            AST_SEL_LINE_LOW: assert (!oct_on || !oct_y_n[oct_sel]);          // R2
            AST_OFF_ALL_HIGH: assert (oct_on || (&oct_y_n));                  // R3
            AST_ONE_LOW_MAX: assert ($countones(~oct_y_n) <= 1);              // R4
        end
        if (hex_known) begin
            AST_HEX_UPPER_IDLE: assert (hex_en_n || hex_sel[SEL_W] || (&hex_y_n[2*N-1:N])); // R5
            AST_HEX_LOWER_IDLE: assert (hex_en_n || !hex_sel[SEL_W] || (&hex_y_n[N-1:0])); // R6
            AST_HEX_OFF: assert (!hex_en_n || (&hex_y_n));                    // R7
            AST_HEX_ONE_LOW: assert ($countones(~hex_y_n) <= 1);              // R7
        end
    end
endmodule

bind bdec_top bdec_chk #(.SEL_W(SEL_W)) u_chk (
    .oct_sel    (oct_sel),
    .oct_en_a_n (oct_en_a_n),
    .oct_en_b_n (oct_en_b_n),
    .oct_en_c   (oct_en_c),
    .oct_y_n    (oct_y_n),
    .hex_sel    (hex_sel),
    .hex_en_n   (hex_en_n),
    .hex_y_n    (hex_y_n)
);

// File: tb/sim_bdec_top.sv
module sim_bdec_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  oct_sel = '0;
    logic        oct_en_a_n = 1'b1;
    logic        oct_en_b_n = 1'b1;
    logic        oct_en_c = 1'b0;
    logic [7:0]  oct_y_n;
    logic [3:0]  hex_sel = '0;
    logic        hex_en_n = 1'b1;
    logic [15:0] hex_y_n;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    bdec_top u0 (
        .oct_sel    (oct_sel),
        .oct_en_a_n (oct_en_a_n),
        .oct_en_b_n (oct_en_b_n),
        .oct_en_c   (oct_en_c),
        .oct_y_n    (oct_y_n),
        .hex_sel    (hex_sel),
        .hex_en_n   (hex_en_n),
        .hex_y_n    (hex_y_n)
    );

    function automatic logic [7:0] exp_oct(input logic [2:0] s, input logic a_n,
                                           input logic b_n, input logic c);
        logic [7:0] r;
        r = 8'hFF;
        if (!a_n && !b_n && c) r[s] = 1'b0;
        return r;
    endfunction

    function automatic logic [15:0] exp_hex(input logic [3:0] s, input logic g_n);
        logic [15:0] r;
        r = 16'hFFFF;
        if (!g_n) r[s] = 1'b0;
        return r;
    endfunction

    task automatic check_oct();
        logic [7:0] e;
        e = exp_oct(oct_sel, oct_en_a_n, oct_en_b_n, oct_en_c);
        checks++;
        if (oct_y_n !== e) begin
            failures++;
            if (e == 8'hFF)
                $display("FAIL R1 R3 sel=%0d en=%b%b%b act=%h exp=%h", oct_sel,
                         oct_en_a_n, oct_en_b_n, oct_en_c, oct_y_n, e);
            else
                $display("FAIL R1 R2 sel=%0d act=%h exp=%h", oct_sel, oct_y_n, e);
        end
        checks++;
        if ($countones(~oct_y_n) > 1) begin
            failures++;
            $display("FAIL R4 lows act=%0d exp<=1", $countones(~oct_y_n));
        end
    endtask

    task automatic check_hex();
        logic [15:0] e;
        e = exp_hex(hex_sel, hex_en_n);
        checks++;
        if (hex_y_n !== e) begin
            failures++;
            if (hex_en_n)
                $display("FAIL R7 sel=%0d act=%h exp=%h", hex_sel, hex_y_n, e);
            else if (!hex_sel[3])
                $display("FAIL R5 sel=%0d act=%h exp=%h", hex_sel, hex_y_n, e);
            else
                $display("FAIL R6 sel=%0d act=%h exp=%h", hex_sel, hex_y_n, e);
        end
    endtask

    task automatic apply(input logic [2:0] s, input logic [2:0] en,
                         input logic [3:0] hs, input logic hg);
        @(posedge clk);
        oct_sel    = s;
        oct_en_a_n = en[2];
        oct_en_b_n = en[1];
        oct_en_c   = en[0];
        hex_sel    = hs;
        hex_en_n   = hg;
        @(negedge clk);
        check_oct();
        check_hex();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: all enables inactive, outputs all high (R3, R7)
        check_oct();
        check_hex();
        rst = 1'b0;
        // Exhaustive sweep of the eight-output unit (R1..R4)
        for (int en = 0; en < 8; en++) begin
            for (int s = 0; s < 8; s++) begin
                apply(3'(s), 3'(en), 4'(s), 1'b1);
            end
        end
        // Exhaustive sweep of the cascade (R5, R6, R7)
        for (int g = 0; g < 2; g++) begin
            for (int s = 0; s < 16; s++) begin
                apply(3'(s), 3'b001, 4'(s), 1'(g));
            end
        end
        // Directed corners: boundary indices and single-enable faults (R1)
        apply(3'd7, 3'b001, 4'd7, 1'b0);
        apply(3'd0, 3'b101, 4'd8, 1'b0);
        apply(3'd7, 3'b011, 4'd15, 1'b0);
        apply(3'd3, 3'b000, 4'd0, 1'b0);
        // Seeded random vectors
        void'($urandom(32'd2024));
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom();
            apply(r[2:0], (r[3] ? 3'b001 : r[6:4]), r[10:7], r[11] & r[12]);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule